// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one data word into an asynchronous serial frame on a single line. A frame is one low start bit, then 7, 8 or 9 data bits, then an optional parity bit, then zero, one or two high stop bits. The line rests high between frames. Bit timing comes from an external baud tick, a one-cycle strobe. Every bit on the line lasts from one tick to the next.

The word and its configuration are offered with a valid/ready handshake. The configuration is the length select, the bit order, the parity mode and the stop count. The block captures all of them in the cycle the handshake completes, so the source may change them while the frame is in flight. After the word is accepted, the line stays high until the next tick. The start bit begins at that tick. When the final bit period ends, a one-cycle completion pulse is raised and the block accepts the next word in that same cycle.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and between frames, `tx_o` is 1, `ready_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: A word is accepted on a clock edge where `valid_i` and `ready_o` are both 1. `tx_o` stays 1 until the next baud tick. From that tick, `tx_o` is 0 for exactly one tick period (the start bit).
- R3: `len_sel_i` selects the data length: 00 gives 7 bits, 01 gives 8 and 10 gives 9. Code 11 is clamped to 9. Only the low bits of `data_i` are sent, and higher bits have no effect on the line.
- R4: When `lsb_first_i` is 0, the data bits go out most significant first. When it is 1, they go out least significant first.
- R5: `par_mode_i` selects the parity bit, which follows the data bits:
  - 00 sends no parity bit.
  - 01 sends a bit that is always 0.
  - 10 sends even parity (the bit makes the total count of ones in data plus parity even).
  - 11 sends odd parity.
- R6: `stop_sel_i` selects the stop bits, each one tick period of 1 on the line: 00 sends none, 01 sends one and 10 sends two. Code 11 sends one.
- R7: `done_o` is high for exactly one clock cycle, the cycle after the tick that ends the last bit of the frame. That last bit is the final stop bit, or the last data or parity bit when there are no stop bits. In that cycle `tx_o` is back at 1.
- R8: `ready_o` is 0 and `busy_o` is 1 from the cycle after acceptance until the completion cycle. `ready_o` returns to 1 in the same cycle that `done_o` is 1.
- R9: Data and configuration are sampled only at acceptance. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | One-cycle strobe marking each bit boundary |
| data_i | input | DATA_W (9) | Word to send, right-aligned |
| valid_i | input | 1 | Word and configuration are offered |
| ready_o | output | 1 | Block can accept a word |
| len_sel_i | input | 2 | Data length select |
| lsb_first_i | input | 1 | Bit order select |
| par_mode_i | input | 2 | Parity mode |
| stop_sel_i | input | 2 | Stop bit count |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle frame completion pulse |

## Verification
The assertions assume that `baud_tick_i` is a single-cycle strobe. They also assume that `valid_i` is held at most until the handshake completes. The stimulus sends ticks at a fixed random period between one and five cycles for each frame. It raises `valid_i` only while the block is idle and drops it after acceptance. While a frame is in flight, the bench overwrites data and configuration with random values, including the clamped length code and the prohibited stop code. This checks that the captured frame is unaffected.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LOAD   = 3'd1,
        PH_START  = 3'd2,
        PH_DATA   = 3'd3,
        PH_PARITY = 3'd4,
        PH_STOP   = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    localparam int unsigned MIN_LEN = 7;

endpackage

// File: rtl/uart_tx_order.sv
// Masks the word to the selected length and arranges it so that bit 0
// is always the first bit on the line.
module uart_tx_order #(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              lsb_first_i,
    output logic [DATA_W-1:0] word_o,
    output logic [DATA_W-1:0] masked_o
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [LEN_W-1:0]  FULL_LEN = LEN_W'(DATA_W);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] reversed;

    assign mask     = ~(ALL_ONES << len_i);
    assign masked_o = data_i & mask;

    for (genvar g = 0; g < DATA_W; g++) begin : g_rev
        assign reversed[g] = masked_o[DATA_W-1-g];
    end

    always_comb begin
        if (lsb_first_i) begin
            word_o = masked_o;
        end else begin
            word_o = reversed >> (FULL_LEN - len_i);
        end
    end

endmodule

// File: rtl/uart_tx_parity.sv
// Parity bit and parity enable for one captured word.
module uart_tx_parity #(
    parameter int unsigned DATA_W = 9
) (
    input  logic [DATA_W-1:0] bits_i,
    input  logic [1:0]        mode_i,
    output logic              par_o,
    output logic              en_o
);
    import uart_tx_pkg::*;

    logic ones_odd;
    assign ones_odd = ^bits_i;

    always_comb begin
        en_o  = 1'b1;
        par_o = 1'b0;
        unique case (mode_i)
            PAR_NONE: en_o  = 1'b0;
            PAR_ZERO: par_o = 1'b0;
            PAR_EVEN: par_o = ones_odd;
            PAR_ODD:  par_o = ~ones_odd;
            default:  en_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int unsigned DATA_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              baud_tick_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    input  logic [1:0]        len_sel_i,
    input  logic              lsb_first_i,
    input  logic [1:0]        par_mode_i,
    input  logic [1:0]        stop_sel_i,
    output logic              tx_o,
    output logic              busy_o,
    output logic              done_o
);
    import uart_tx_pkg::*;

    localparam int unsigned LEN_W = $clog2(DATA_W + 1);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DATA_W);

    typedef struct packed {
        phase_e            phase;
        logic [DATA_W-1:0] shreg;
        logic [LEN_W-1:0]  left;
        logic [1:0]        stops;
        logic              par_en;
        logic              par_bit;
        logic [1:0]        par_mode;
        logic              tx;
        logic              done;
    } state_t;

    localparam state_t RESET_STATE = '{
        phase:    PH_IDLE,
        shreg:    '0,
        left:     '0,
        stops:    2'd0,
        par_en:   1'b0,
        par_bit:  1'b0,
        par_mode: 2'b00,
        tx:       1'b1,
        done:     1'b0
    };

    state_t state_d, state_q;

    // length decode with clamp
    logic [LEN_W:0]    len_raw;
    logic [LEN_W-1:0]  len_sel;
    logic [DATA_W-1:0] ordered_word;
    logic [DATA_W-1:0] masked_word;
    logic              par_bit;
    logic              par_en;
    logic [1:0]        stop_cnt;
    logic              accept;

    assign len_raw = (LEN_W+1)'(MIN_LEN) + (LEN_W+1)'(len_sel_i);
    assign len_sel = (len_raw > (LEN_W+1)'(DATA_W)) ? MAX_LEN : len_raw[LEN_W-1:0];

    always_comb begin
        unique case (stop_sel_i)
            2'b00:   stop_cnt = 2'd0;
            2'b10:   stop_cnt = 2'd2;
            default: stop_cnt = 2'd1;
        endcase
    end

    uart_tx_order #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) order_i (
        .data_i      (data_i),
        .len_i       (len_sel),
        .lsb_first_i (lsb_first_i),
        .word_o      (ordered_word),
        .masked_o    (masked_word)
    );

    uart_tx_parity #(
        .DATA_W (DATA_W)
    ) parity_i (
        .bits_i (masked_word),
        .mode_i (par_mode_i),
        .par_o  (par_bit),
        .en_o   (par_en)
    );

    assign accept = valid_i && (state_q.phase == PH_IDLE);

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        unique case (state_q.phase)
            PH_IDLE: begin
                state_d.tx = 1'b1;
                if (accept) begin
                    state_d.phase    = PH_LOAD;
                    state_d.shreg    = ordered_word;
                    state_d.left     = len_sel;
                    state_d.stops    = stop_cnt;
                    state_d.par_en   = par_en;
                    state_d.par_bit  = par_bit;
                    state_d.par_mode = par_mode_i;
                end
            end
            PH_LOAD: begin
                if (baud_tick_i) begin
                    state_d.phase = PH_START;
                    state_d.tx    = 1'b0;
                end
            end
            PH_START: begin
                if (baud_tick_i) begin
                    state_d.phase = PH_DATA;
                    state_d.tx    = state_q.shreg[0];
                    state_d.shreg = state_q.shreg >> 1;
                    state_d.left  = state_q.left - 1'b1;
                end
            end
            PH_DATA: begin
                if (baud_tick_i) begin
                    if (state_q.left != '0) begin
                        state_d.tx    = state_q.shreg[0];
                        state_d.shreg = state_q.shreg >> 1;
                        state_d.left  = state_q.left - 1'b1;
                    end else if (state_q.par_en) begin
                        state_d.phase = PH_PARITY;
                        state_d.tx    = state_q.par_bit;
                    end else if (state_q.stops != 2'd0) begin
                        state_d.phase = PH_STOP;
                        state_d.tx    = 1'b1;
                        state_d.stops = state_q.stops - 2'd1;
                    end else begin
                        state_d.phase = PH_IDLE;
                        state_d.tx    = 1'b1;
                        state_d.done  = 1'b1;
                    end
                end
            end
            PH_PARITY: begin
                if (baud_tick_i) begin
                    state_d.tx = 1'b1;
                    if (state_q.stops != 2'd0) begin
                        state_d.phase = PH_STOP;
                        state_d.stops = state_q.stops - 2'd1;
                    end else begin
                        state_d.phase = PH_IDLE;
                        state_d.done  = 1'b1;
                    end
                end
            end
            PH_STOP: begin
                if (baud_tick_i) begin
                    state_d.tx = 1'b1;
                    if (state_q.stops != 2'd0) begin
                        state_d.stops = state_q.stops - 2'd1;
                    end else begin
                        state_d.phase = PH_IDLE;
                        state_d.done  = 1'b1;
                    end
                end
            end
            default: state_d = RESET_STATE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    assign tx_o    = state_q.tx;
    assign done_o  = state_q.done;
    assign busy_o  = (state_q.phase != PH_IDLE);
    assign ready_o = (state_q.phase == PH_IDLE);

    // ---------------- assertions ----------------
    assert_idle_line_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.phase == PH_IDLE || state_q.phase == PH_LOAD) |-> tx_o);

    assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.phase == PH_START) |-> !tx_o);

    assert_len_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q.left <= MAX_LEN);

    assert_zero_parity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.phase == PH_PARITY && state_q.par_mode == PAR_ZERO) |-> !tx_o);

    assert_stop_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.phase == PH_STOP) |-> tx_o);

    assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_line_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> tx_o);

    assert_done_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ready_o);

    assert_accept_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && ready_o) |=> (!ready_o && busy_o));

    assert_cfg_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.phase != PH_IDLE && $past(state_q.phase) != PH_IDLE)
            |-> $stable(state_q.par_mode));

endmodule

// File: tb/uart_frame_tx_tb_top.sv
`timescale 1ns/1ps
module uart_frame_tx_tb_top;

    localparam int DATA_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              baud_tick = 1'b0;
    logic [DATA_W-1:0] data = '0;
    logic              valid = 1'b0;
    logic [1:0]        len_sel = 2'b01;
    logic              lsb_first = 1'b0;
    logic [1:0]        par_mode = 2'b00;
    logic [1:0]        stop_sel = 2'b01;
    logic              ready, tx, busy, done;

    int checks = 0;
    int fails  = 0;
    int tcnt   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    uart_frame_tx #(.DATA_W(DATA_W)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .baud_tick_i (baud_tick),
        .data_i      (data),
        .valid_i     (valid),
        .ready_o     (ready),
        .len_sel_i   (len_sel),
        .lsb_first_i (lsb_first),
        .par_mode_i  (par_mode),
        .stop_sel_i  (stop_sel),
        .tx_o        (tx),
        .busy_o      (busy),
        .done_o      (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int len_of(input logic [1:0] sel);
        return (sel == 2'b00) ? 7 : (sel == 2'b01) ? 8 : 9;
    endfunction

    function automatic int stops_of(input logic [1:0] sel);
        return (sel == 2'b00) ? 0 : (sel == 2'b10) ? 2 : 1;
    endfunction

    // Expected tick samples: load(1), start(0), data, parity, stops
    function automatic int build(input logic [DATA_W-1:0] d, input logic [1:0] ls,
                                 input logic lsb, input logic [1:0] pm,
                                 input logic [1:0] ss, output logic [31:0] bits);
        int n = 0;
        int l = len_of(ls);
        logic ones = 1'b0;
        bits = '0;
        bits[n++] = 1'b1;
        bits[n++] = 1'b0;
        for (int i = 0; i < l; i++) begin
            bits[n++] = lsb ? d[i] : d[l-1-i];
            ones ^= d[i];
        end
        if (pm == 2'b01) bits[n++] = 1'b0;
        else if (pm == 2'b10) bits[n++] = ones;
        else if (pm == 2'b11) bits[n++] = ~ones;
        for (int i = 0; i < stops_of(ss); i++) bits[n++] = 1'b1;
        return n;
    endfunction

    task automatic step(input int per, output logic txs, output logic tk,
                        output logic dn, output logic rd, output logic bz);
        @(negedge clk);
        txs = tx; dn = done; rd = ready; bz = busy;
        tcnt++;
        if (tcnt >= per) begin tcnt = 0; baud_tick = 1'b1; end
        else baud_tick = 1'b0;
        tk = baud_tick;
    endtask

    task automatic run_frame(input logic [DATA_W-1:0] d, input logic [1:0] ls,
                             input logic lsb, input logic [1:0] pm,
                             input logic [1:0] ss, input int per, input string tag);
        logic [31:0] expb, got;
        int n_exp, n_got;
        logic txs, tk, dn, rd, bz;
        bit saw_done = 1'b0;
        bit ready_ok = 1'b1;
        bit tx_at_done = 1'b0;
        n_exp = build(d, ls, lsb, pm, ss, expb);
        got = '0; n_got = 0;
        @(negedge clk);
        baud_tick = 1'b0; tcnt = 0;
        data = d; len_sel = ls; lsb_first = lsb; par_mode = pm; stop_sel = ss;
        valid = 1'b1;
        chk(ready === 1'b1, "R1", {tag, " ready before accept"}, int'(ready), 1);
        @(negedge clk);
        valid = 1'b0;
        chk(ready === 1'b0 && busy === 1'b1, "R8", {tag, " ready after accept"}, int'(ready), 0);
        // R9: scramble inputs during the frame
        data = DATA_W'($urandom); len_sel = 2'($urandom); lsb_first = 1'($urandom);
        par_mode = 2'($urandom); stop_sel = 2'($urandom);
        for (int c = 0; c < 400; c++) begin
            step(per, txs, tk, dn, rd, bz);
            if (dn === 1'b1) begin
                saw_done = 1'b1; tx_at_done = txs;
                if (rd !== 1'b1 || bz !== 1'b0) ready_ok = 1'b0;
                break;
            end
            if (rd !== 1'b0 || bz !== 1'b1) ready_ok = 1'b0;
            if (tk === 1'b1) begin
                if (n_got < 32) got[n_got] = txs;
                n_got++;
            end
        end
        baud_tick = 1'b0;
        chk(saw_done, "R7", {tag, " done seen"}, int'(saw_done), 1);
        chk(tx_at_done === 1'b1, "R7", {tag, " line high at done"}, int'(tx_at_done), 1);
        chk(ready_ok, "R8", {tag, " ready low until done"}, int'(ready_ok), 1);
        chk(n_got == n_exp, "R6", {tag, " bit period count"}, n_got, n_exp);
        chk(got == expb, "R9", {tag, " line bits (R2 R3 R4 R5)"}, int'(got), int'(expb));
        step(per, txs, tk, dn, rd, bz);
        baud_tick = 1'b0;
        chk(dn === 1'b0 && txs === 1'b1 && rd === 1'b1, "R7", {tag, " single pulse, idle after"},
            int'(dn), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk(tx === 1'b1, "R1", "reset tx", int'(tx), 1);
        chk(ready === 1'b1 && busy === 1'b0, "R1", "reset ready/busy", int'(ready), 1);
        chk(done === 1'b0, "R1", "reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx === 1'b1 && done === 1'b0, "R1", "idle after reset", int'(tx), 1);

        // directed corners
        run_frame(9'h0A5, 2'b01, 1'b0, 2'b00, 2'b01, 3, "R4 msb8 nopar");
        run_frame(9'h0A5, 2'b01, 1'b1, 2'b00, 2'b01, 3, "R4 lsb8");
        run_frame(9'h1FF, 2'b01, 1'b0, 2'b01, 2'b01, 2, "R5 zero parity");
        run_frame(9'h007, 2'b01, 1'b1, 2'b10, 2'b01, 4, "R5 even");
        run_frame(9'h007, 2'b01, 1'b1, 2'b11, 2'b01, 4, "R5 odd");
        run_frame(9'h155, 2'b00, 1'b0, 2'b10, 2'b00, 2, "R3 len7 zero stops");
        run_frame(9'h1C3, 2'b10, 1'b0, 2'b11, 2'b10, 5, "R3 len9 two stops");
        run_frame(9'h1C3, 2'b11, 1'b1, 2'b00, 2'b11, 1, "R6 clamp len, stop11");
        run_frame(9'h180, 2'b00, 1'b1, 2'b00, 2'b00, 1, "R3 high bits ignored");

        for (int k = 0; k < 40; k++) begin
            run_frame(DATA_W'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
                      2'($urandom), 1 + int'($urandom_range(4)), "random R2");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule